// File: doc/BRIEF.md
# Reflected GF(2^128) Field Multiplier

This block multiplies two elements of the binary field GF(2^128) reduced by X^128 + X^7 + X^2 + X + 1. Elements use the bit-reflected convention of GCM authentication. Each 128-bit operand port is packed exactly as the bytes arrive: the first byte sits in bits [127:120], and the most significant bit of each byte comes first. Under that convention bit 127 of a port carries the coefficient of X^0 and bit 0 carries the coefficient of X^127.

The block never reorders bits. Carry-less multiplication commutes with mirroring, so the engine multiplies the port words as they stand. A sequential shift-and-XOR engine consumes a fixed number of multiplier bits per cycle and builds the 255-bit mirrored product. A single combinational fold stage then moves that product up by one bit to fill 256 bits. It cancels the high half one 32-bit word at a time using fixed shift-and-XOR taps, and keeps the upper 128 bits as the answer.

A caller pulses `start_i` with both operands while the block is idle. Exactly `W/BITS_PER_CYC + 1` clock edges later, `done_o` is high for one cycle and `result_o` holds the product. `result_o` then stays unchanged until the next completion.

Top module: `refl_gf128_mult`

## Requirements
- R1: `result_o` equals the GCM field product of the two operands. Bit 127 of every 128-bit port is the coefficient of X^0, and bit 0 is the coefficient of X^127.
- R2: The product is commutative: swapping `opa_i` and `opb_i` gives the same `result_o`.
- R3: The element 1 is encoded as 0x80 followed by fifteen 0x00 bytes (only bit 127 set). Multiplying by it returns the other operand unchanged.
- R4: An operand of zero gives a zero result.
- R5: Reduction is correct at the wrap. X^127 (only bit 0 set) times X (only bit 126 set) gives X^7+X^2+X+1, which is 0xE1 followed by fifteen 0x00 bytes.
- R6: `done_o` rises exactly 17 edges after the edge that accepts `start_i` (with the default 8 bits per cycle), and it stays high for exactly one cycle.
- R7: The block ignores `start_i` while `busy_o` is high. The operands are captured at acceptance, so later changes on `opa_i` or `opb_i` do not alter the result, and no extra completion occurs.
- R8: A `start_i` presented in the same cycle as `done_o` is accepted, which allows back-to-back operations.
- R9: `result_o` changes only at the edge that raises `done_o`.
- R10: After a synchronous active-low reset, `busy_o` is 0, `done_o` is 0 and `result_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Request a multiplication; taken only while idle |
| opa_i | input | 128 | First operand, reflected byte-natural packing |
| opb_i | input | 128 | Second operand, reflected byte-natural packing |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 128 | Field product, held until the next completion |

## Verification
Two events can coincide in one cycle: a completion pulse on `done_o` and the acceptance of the next request. The bench waits for `done_o` and raises `start_i` in that same cycle. The scoreboard then expects both the old product on the current pulse and the new product exactly 17 edges later. Requests raised while `busy_o` is high, including in the fold cycle just before completion, must produce no entry. An unmatched completion, or a wrong value on a matched one, counts as a mismatch.

// File: rtl/refl_gf_pkg.sv
// Package: shared constants, state encoding and fold tap functions for the
// reflected GF(2^128) multiplier. Assumes 32-bit words in the fold stage.
package refl_gf_pkg;

    localparam int FIELD_W = 128;
    localparam int WORD_W  = 32;
    localparam int PROD_W  = 2 * FIELD_W - 1;
    localparam int WIDE_W  = 2 * FIELD_W;
    localparam int HALF_WD = FIELD_W / WORD_W;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_MUL  = 2'd1,
        ST_FOLD = 2'd2
    } mul_state_e;

    // Taps that land one word further down (degrees i-128, i-127, i-126, i-121).
    function automatic logic [WORD_W-1:0] tap_far(input logic [WORD_W-1:0] w);
        return w ^ (w >> 1) ^ (w >> 2) ^ (w >> 7);
    endfunction

    // Bits of the same taps that spill into the neighbouring word.
    function automatic logic [WORD_W-1:0] tap_near(input logic [WORD_W-1:0] w);
        return (w << 31) ^ (w << 30) ^ (w << 25);
    endfunction

endpackage

// File: rtl/refl_clmul_engine.sv
// Module: sequential carry-less multiplier. Each step takes the top
// BITS_PER_CYC bits of the multiplier and folds them into a shifting
// accumulator. Assumes BITS_PER_CYC divides W and that load_i and step_i are
// never high together. After W/BITS_PER_CYC steps, prod_o holds a*b.
module refl_clmul_engine #(
    parameter int W            = 128,
    parameter int BITS_PER_CYC = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             step_i,
    input  logic [W-1:0]     opa_i,
    input  logic [W-1:0]     opb_i,
    output logic [2*W-2:0]   prod_o
);

    localparam int PW = 2 * W - 1;
    localparam int K  = BITS_PER_CYC;

    logic [W-1:0]        mcand_q;
    logic [W-1:0]        mplier_q;
    logic [PW-1:0]       acc_q;
    logic [K:0][PW-1:0]  pp_chain;
    logic [PW-1:0]       mcand_ext;

    assign mcand_ext = {{(W-1){1'b0}}, mcand_q};
    assign pp_chain[0] = '0;

    // Partial products: bit j of the current chunk weighs X^j inside the chunk.
    for (genvar j = 0; j < K; j++) begin : g_pp
        assign pp_chain[j+1] = pp_chain[j]
                             ^ (mplier_q[W-K+j] ? (mcand_ext << j) : '0);
    end

    // Capture operands on load, advance the accumulator one chunk per step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mcand_q  <= '0;
            mplier_q <= '0;
            acc_q    <= '0;
        end else if (load_i) begin
            mcand_q  <= opa_i;
            mplier_q <= opb_i;
            acc_q    <= '0;
        end else if (step_i) begin
            mplier_q <= mplier_q << K;
            acc_q    <= (acc_q << K) ^ pp_chain[K];
        end
    end

    assign prod_o = acc_q;

    AST_LOAD_STEP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(load_i && step_i)); // R7

    AST_LOAD_CLEARS_ACC: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (acc_q == '0)); // R7

endmodule

// File: rtl/refl_gf_fold.sv
// Module: combinational realignment and reduction. It shifts the 255-bit
// mirrored product left by one bit into 256 bits. Word 0 holds X^255..X^224,
// and words 0..3 are folded in order into the words below them. The answer
// is words 4..7; the upper words are left as they are and then dropped.
module refl_gf_fold
    import refl_gf_pkg::*;
(
    input  logic [PROD_W-1:0]  prod_i,
    output logic [FIELD_W-1:0] res_o
);

    logic [HALF_WD:0][WIDE_W-1:0] stage;

    assign stage[0] = {prod_i, 1'b0};

    // One stage per high word; later stages see earlier injections.
    for (genvar i = 0; i < HALF_WD; i++) begin : g_fold
        logic [WORD_W-1:0] lw;
        logic [WIDE_W-1:0] far_ext;
        logic [WIDE_W-1:0] near_ext;
        assign lw       = stage[i][WORD_W*i +: WORD_W];
        assign far_ext  = {{(WIDE_W-WORD_W){1'b0}}, tap_far(lw)}  << (WORD_W * (i + HALF_WD));
        assign near_ext = {{(WIDE_W-WORD_W){1'b0}}, tap_near(lw)} << (WORD_W * (i + HALF_WD - 1));
        assign stage[i+1] = stage[i] ^ far_ext ^ near_ext;
    end

    assign res_o = stage[HALF_WD][WIDE_W-1:FIELD_W];

endmodule

// File: rtl/refl_gf128_mult.sv
// Module: top of the reflected GF(2^128) multiplier. It holds the
// start/done control and ties the multiply engine to the fold stage.
// Assumes operands use the reflected byte-natural packing (bit 127 = X^0).
// Latency from the accepting edge to done is W/BITS_PER_CYC + 1 edges.
module refl_gf128_mult
    import refl_gf_pkg::*;
#(
    parameter int BITS_PER_CYC = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start_i,
    input  logic [127:0]   opa_i,
    input  logic [127:0]   opb_i,
    output logic           busy_o,
    output logic           done_o,
    output logic [127:0]   result_o
);

    localparam int STEPS = FIELD_W / BITS_PER_CYC;
    localparam int LAT   = STEPS + 1;
    localparam int CW    = $clog2(STEPS + 1);
    localparam int LW    = $clog2(LAT + 2);

    mul_state_e            state_q;
    logic [CW-1:0]         step_cnt_q;
    logic                  load;
    logic                  step;
    logic [PROD_W-1:0]     prod;
    logic [FIELD_W-1:0]    folded;
    logic [FIELD_W-1:0]    result_q;
    logic                  done_q;

    assign load = (state_q == ST_IDLE) && start_i;
    assign step = (state_q == ST_MUL);

    // Sequence idle -> multiply chunks -> fold -> idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            step_cnt_q <= '0;
        end else begin
            case (state_q)
                ST_IDLE: if (start_i) begin
                    state_q    <= ST_MUL;
                    step_cnt_q <= '0;
                end
                ST_MUL: begin
                    step_cnt_q <= step_cnt_q + 1'b1;
                    if (step_cnt_q == CW'(STEPS - 1)) state_q <= ST_FOLD;
                end
                ST_FOLD: state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Register the reduced product and the completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_q <= '0;
            done_q   <= 1'b0;
        end else begin
            done_q <= (state_q == ST_FOLD);
            if (state_q == ST_FOLD) result_q <= folded;
        end
    end

    refl_clmul_engine #(
        .W            (FIELD_W),
        .BITS_PER_CYC (BITS_PER_CYC)
    ) u_engine (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load),
        .step_i (step),
        .opa_i  (opa_i),
        .opb_i  (opb_i),
        .prod_o (prod)
    );

    refl_gf_fold u_fold (
        .prod_i (prod),
        .res_o  (folded)
    );

    assign busy_o   = (state_q != ST_IDLE);
    assign done_o   = done_q;
    assign result_o = result_q;

    // Latency monitor: counts edges since the last accepted start.
    logic [LW-1:0] lat_cnt_q;
    always_ff @(posedge clk) begin
        if (!rst_n)       lat_cnt_q <= '0;
        else if (load)    lat_cnt_q <= '0;
        else if (busy_o)  lat_cnt_q <= lat_cnt_q + 1'b1;
    end

    AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (lat_cnt_q == LW'(LAT))); // R6

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R6

    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(result_o)); // R9

    AST_NO_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i && state_q == ST_MUL) |=> busy_o); // R7

    AST_DONE_ACCEPTS: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && start_i) |=> busy_o); // R8

endmodule

// File: tb/refl_gf128_mult_tb.sv
// Scoreboard bench: the driver queues expected products, and the monitor
// pops and compares them on every done pulse.
module refl_gf128_mult_tb;

    localparam int LAT = 17;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic [127:0] opa_i = '0;
    logic [127:0] opb_i = '0;
    logic         busy_o;
    logic         done_o;
    logic [127:0] result_o;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit finished = 0;

    logic [127:0] exp_q[$];
    int           acc_q[$];
    string        tag_q[$];
    logic [127:0] last_res = '0;

    always #2.5 clk = ~clk;   // 200 MHz

    always @(posedge clk) cyc <= cyc + 1;

    refl_gf128_mult u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .opa_i    (opa_i),
        .opb_i    (opb_i),
        .busy_o   (busy_o),
        .done_o   (done_o),
        .result_o (result_o)
    );

    // Independent model: bitwise GCM multiply, leftmost bit = X^0.
    function automatic logic [127:0] gf_ref(input logic [127:0] x, input logic [127:0] y);
        logic [127:0] z = '0;
        logic [127:0] v = y;
        for (int i = 0; i < 128; i++) begin
            if (x[127-i]) z ^= v;
            if (v[0]) v = (v >> 1) ^ {8'hE1, 120'h0};
            else      v = v >> 1;
        end
        return z;
    endfunction

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Driver: wait for idle, present one request, and queue what it must give.
    task automatic issue(input string req, input logic [127:0] a, input logic [127:0] b,
                         input logic [127:0] exp);
        @(negedge clk);
        while (busy_o) @(negedge clk);
        opa_i = a; opb_i = b; start_i = 1'b1;
        exp_q.push_back(exp); acc_q.push_back(cyc + 1); tag_q.push_back(req);
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (busy_o || exp_q.size() != 0) @(negedge clk);
    endtask

    // Monitor: compare value and latency on done, and check R9 hold otherwise.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (done_o) begin
                if (exp_q.size() == 0) begin
                    n_chk++; n_bad++;
                    $display("FAIL R7 unexpected done actual=%h expected=none", result_o);
                end else begin
                    logic [127:0] e;
                    int a;
                    string t;
                    e = exp_q.pop_front(); a = acc_q.pop_front(); t = tag_q.pop_front();
                    check(t, result_o, e);
                    check("R6 latency", 128'(cyc - a), 128'(LAT));
                end
                last_res = result_o;
            end else if (result_o !== last_res) begin
                check("R9 hold", result_o, last_res);
                last_res = result_o;
            end
        end
    end

    logic [127:0] one_e  = {8'h80, 120'h0};
    logic [127:0] wrap_e = {8'hE1, 120'h0};

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check("R10 busy", 128'(busy_o), 128'(0));
        check("R10 done", 128'(done_o), 128'(0));
        check("R10 result", result_o, '0);

        // R5: X^127 * X wraps to X^7+X^2+X+1.
        issue("R5 wrap", 128'h1, {2'b01, 126'h0}, wrap_e);
        // R3: identity on either side.
        issue("R3 identity a", one_e, 128'h0123456789abcdef_fedcba9876543210, 128'h0123456789abcdef_fedcba9876543210);
        issue("R3 identity b", 128'hdeadbeef_00000000_cafef00d_11111111, one_e, 128'hdeadbeef_00000000_cafef00d_11111111);
        // R4: zero operands.
        issue("R4 zero a", '0, 128'hffffffff_ffffffff_ffffffff_ffffffff, '0);
        issue("R4 zero b", 128'h5555aaaa_5555aaaa_5555aaaa_5555aaaa, '0, '0);
        // R1: known GCM vector and model cross-check.
        issue("R1 vector", 128'h0388dace60b6a392f328c2b971b2fe78, 128'h66e94bd4ef8a2c3b884cfa59ca342b2e,
              128'h5e2ec746917062882c85b0685353deb7);
        issue("R1 all ones", '1, '1, gf_ref('1, '1));
        // R2: swapped operands.
        issue("R2 swap ab", 128'h0f1e2d3c4b5a6978_8796a5b4c3d2e1f0, 128'h13579bdf2468ace0_fdb97531eca86420,
              gf_ref(128'h0f1e2d3c4b5a6978_8796a5b4c3d2e1f0, 128'h13579bdf2468ace0_fdb97531eca86420));
        issue("R2 swap ba", 128'h13579bdf2468ace0_fdb97531eca86420, 128'h0f1e2d3c4b5a6978_8796a5b4c3d2e1f0,
              gf_ref(128'h0f1e2d3c4b5a6978_8796a5b4c3d2e1f0, 128'h13579bdf2468ace0_fdb97531eca86420));
        for (int k = 0; k < 16; k++) begin
            logic [127:0] ra;
            logic [127:0] rb;
            ra = {$urandom, $urandom, $urandom, $urandom};
            rb = {$urandom, $urandom, $urandom, $urandom};
            issue("R1 random", ra, rb, gf_ref(ra, rb));
        end
        wait_idle();

        // R7: start while busy (mid-multiply and in the fold cycle) is ignored.
        begin
            logic [127:0] a0 = 128'h00112233_44556677_8899aabb_ccddeeff;
            logic [127:0] b0 = 128'hffeeddcc_bbaa9988_77665544_33221100;
            issue("R7 captured", a0, b0, gf_ref(a0, b0));
            repeat (3) @(negedge clk);
            opa_i = '1; opb_i = one_e; start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0; opa_i = '0;
            while (u_dut.busy_o && !done_o) begin
                @(negedge clk);
                if (busy_o) begin
                    start_i = 1'b1;
                    opb_i = ~opb_i;
                end
            end
            start_i = 1'b0;
            wait_idle();
            repeat (LAT + 3) @(negedge clk);
            check("R7 no extra done", 128'(exp_q.size()), 128'(0));
        end

        // R8: start in the done cycle is accepted.
        begin
            logic [127:0] a1 = 128'hcafebabe_0badf00d_12345678_9abcdef0;
            logic [127:0] b1 = 128'h0fedcba9_87654321_deadbeef_feedface;
            issue("R8 first", a1, b1, gf_ref(a1, b1));
            while (!done_o) @(negedge clk);
            opa_i = b1; opb_i = wrap_e; start_i = 1'b1;
            exp_q.push_back(gf_ref(b1, wrap_e)); acc_q.push_back(cyc + 1); tag_q.push_back("R8 back-to-back");
            @(negedge clk);
            start_i = 1'b0;
            check("R8 accepted", 128'(busy_o), 128'(1));
            wait_idle();
        end

        repeat (4) @(negedge clk);
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    // Watchdog: an expired run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule